// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational two-operand adder with carry-in. By default it is 16 bits wide. The operand bits are split into contiguous blocks whose lengths grow by one from the least significant end: 2, 3, 4 and 5 bits, with the remaining bits forming a final block. Each bit first gets a propagate signal (the XOR of its operand bits) and a generate signal (their AND).

The lowest block ripples its carry straight from the external carry-in. Every higher block builds two carry chains in parallel, one assuming an incoming carry of 0 and one assuming 1. The carry that really arrives from the block below drives a multiplexer. That multiplexer picks the block's carry vector and its carry-out together. Each sum bit is then the bit's propagate XOR the selected carry into that bit. The growing block lengths give the higher blocks more time to finish both chains before the selecting carry arrives. The block is dropped into a datapath wherever a single-cycle add is needed.

Top module: `csel_sqrt_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, taken as unsigned integers, for every input combination.
- R2: `cout_o` equals bit WIDTH (bit 16 by default) of `a_i + b_i + cin_i`.
- R3: The blocks start at bits 0, 2, 5, 9 and 14 and have lengths 2, 3, 4, 5 and 2. The selected carry entering each block equals the true carry out of the sum of all lower bits, so a carry started at bit 0 ripples correctly across every block boundary.
- R4: The lowest block (bits 0 and 1) takes `cin_i` directly, so `cin_i` = 1 with zero operands gives a sum of 1.
- R5: In every selectable block, the carry-out of the chain that assumes carry-in 0 never exceeds the carry-out of the chain that assumes carry-in 1.
- R6: When every propagate bit of a block is 1, that block's selected carry-out equals its incoming carry. With `a_i` = 0x5555 and `b_i` = 0xAAAA, `sum_o` is 0xFFFF plus `cin_i` (wrapping to 0) and `cout_o` equals `cin_i`.
- R7: Two boundary cases give fixed results. All-ones operands with `cin_i` = 1 give `sum_o` = 0xFFFF and `cout_o` = 1. Zero operands with `cin_i` = 0 give zero on both outputs.
- R8: The block holds no state. Its outputs depend only on the present inputs, with no clock and no latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Both results, `sum_o` and `cout_o`, are due in the same cycle the operands change, because no register lies between the inputs and the outputs. The bench drives each vector just after a rising edge and compares both outputs against an integer reference at the following falling edge, once the combinational paths have settled. The vectors cover the fixed corner cases, carries that ripple up to each block boundary, all-propagate patterns that pass the carry through every block, and a long run of random operands.

// File: rtl/csel_sqrt_adder.sv
module csel_sqrt_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  function automatic int blk_lo(input int k);
    return k * (k + 3) / 2;
  endfunction

  function automatic int blk_count();
    int n;
    n = 0;
    while (blk_lo(n) < WIDTH) n++;
    return n;
  endfunction

  localparam int NBLK = blk_count();

  logic [WIDTH-1:0] prop, gen, cvec;
  logic [NBLK:0]    bcarry;

  assign prop      = a_i ^ b_i;
  assign gen       = a_i & b_i;
  assign bcarry[0] = cin_i;

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    localparam int LO  = blk_lo(k);
    localparam int LEN = (k + 2 < WIDTH - LO) ? k + 2 : WIDTH - LO;

    logic [LEN:0] sel;

    if (k == 0) begin : g_direct
      always_comb begin
        sel[0] = bcarry[0];
        for (int j = 0; j < LEN; j++)
          sel[j+1] = gen[LO+j] | (prop[LO+j] & sel[j]);
      end
    end else begin : g_select
      logic [LEN:0] ch0, ch1;
      logic         allp;
      logic [LO:0]  pre;

      always_comb begin
        ch0[0] = 1'b0;
        ch1[0] = 1'b1;
        for (int j = 0; j < LEN; j++) begin
          ch0[j+1] = gen[LO+j] | (prop[LO+j] & ch0[j]);
          ch1[j+1] = gen[LO+j] | (prop[LO+j] & ch1[j]);
        end
      end

      assign sel  = bcarry[k] ? ch1 : ch0;
      assign allp = &prop[LO +: LEN];
      assign pre  = {1'b0, a_i[LO-1:0]} + {1'b0, b_i[LO-1:0]} + (LO+1)'(cin_i);

      always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
          p_cand_order_r5: assert (!ch0[LEN] || ch1[LEN])
            else $error("R5: carry-0 chain above carry-1 chain in block %0d", k);
          p_bypass_r6: assert (!allp || (sel[LEN] == bcarry[k]))
            else $error("R6: all-propagate block %0d did not pass its carry", k);
          p_blk_carry_r3: assert (bcarry[k] == pre[LO])
            else $error("R3: wrong carry into block %0d", k);
        end
      end
    end

    assign cvec[LO +: LEN] = sel[LEN-1:0];
    assign bcarry[k+1]     = sel[LEN];
  end

  assign sum_o  = prop ^ cvec;
  assign cout_o = bcarry[NBLK];

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i);

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      p_sum_ok_r1: assert (sum_o == ref_total[WIDTH-1:0])
        else $error("R1: sum mismatch");
      p_cout_ok_r2: assert (cout_o == ref_total[WIDTH])
        else $error("R2: carry-out mismatch");
    end
  end

endmodule

// File: tb/csel_sqrt_adder_test.sv
module csel_sqrt_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NRAND = 3000;
  localparam int WATCHDOG = 20000;
  localparam int BND [5] = '{2, 5, 9, 14, 16};

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int applied = 0;
  int miscmp  = 0;
  bit done    = 1'b0;

  csel_sqrt_adder #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input string req);
    longint unsigned total;
    logic [W:0] expv;
    @(posedge clk);
    a = av; b = bv; cin = cv;
    total = longint'(av) + longint'(bv) + longint'(cv);
    expv = total[W:0];
    @(negedge clk);
    applied++;
    if (sum !== expv[W-1:0] || cout !== expv[W]) begin
      miscmp++;
      $display("FAIL %s: a=%h b=%h cin=%0d got cout=%0d sum=%h expected cout=%0d sum=%h",
               req, av, bv, cv, cout, sum, expv[W], expv[W-1:0]);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    apply('0, '0, 1'b0, "R7 zero plus zero");
    apply('1, '1, 1'b1, "R7 all ones with carry-in");
    apply('1, '0, 1'b1, "R2 full-width ripple to carry-out");
    apply('0, '0, 1'b1, "R4 carry-in alone");
    apply(16'h0001, 16'h0000, 1'b1, "R4 carry-in into bit 1");
    for (int i = 0; i < 5; i++) begin
      logic [W-1:0] mask;
      mask = W'((32'd1 << BND[i]) - 32'd1);
      apply(mask, '0, 1'b1, "R3 carry ripples to boundary");
      apply(mask, 16'h0001, 1'b0, "R3 generate ripples to boundary");
      apply(mask, mask, 1'b1, "R3 doubled mask at boundary");
    end
    apply(16'h5555, 16'hAAAA, 1'b0, "R6 all propagate carry-in 0");
    apply(16'h5555, 16'hAAAA, 1'b1, "R6 all propagate carry-in 1");
    apply(16'h3C3C, 16'hC3C3, 1'b1, "R6 all propagate mixed pattern");
    apply(16'h8000, 16'h8000, 1'b0, "R5 top generate only");
    apply(16'h0200, 16'h0200, 1'b0, "R5 generate at block base");
    for (int i = 0; i < NRAND; i++)
      apply(W'($urandom), W'($urandom), 1'($urandom), "R1 R8 random operands");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end
endmodule